// File: doc/BRIEF.md
# RF Burst Power-Up Sequencer

This controller runs one transmission burst of a low-power UHF transmitter. A start request moves it out of standby. It raises the oscillator/PLL enable and counts a start-up interval on the free-running internal clock. It then moves its own clock over to the transmitter's crystal-derived clock, enables the power amplifier and serialises a stream of bytes. After the last byte it powers down in the reverse order: the amplifier goes off, the logic returns to the internal clock, and the enable drops. A one-cycle done pulse ends the burst.

Two modulation paths are offered, and the mode is chosen at the start request. In amplitude keying the amplifier enable itself carries the data. In frequency keying the amplifier stays on and a crystal load-capacitor switch carries the data. A closed switch pulls the crystal down to the lower of the two frequencies.

Bit timing comes from the transmitter clock through a divider that is loaded at start, so the data rate has crystal accuracy. Bytes arrive over a ready/valid handshake, and a flag on the final byte ends the burst.

Top module: `rf_burst_seq`

## Requirements
- R1: While reset is held and after it is released, tx_enable_o, pa_enable_o, fsk_sw_o, busy_o, done_o and byte_ready_o are all 0 (standby).
- R2: A start_i pulse in standby raises tx_enable_o and busy_o at the next internal clock edge, with pa_enable_o still 0. fsk_mode_i (1 = frequency keying, 0 = amplitude keying) and bit_div_i are captured at that edge.
- R3: After tx_enable_o rises, pa_enable_o stays 0 and no byte is accepted for at least WARM_CYCLES internal clock cycles. The logic stays on the internal clock for that whole time.
- R4: The move between the internal and transmitter clocks is glitch-free. The two clock gates are never open together, and the transmitter gate opens only after the internal gate has closed. The sequencer runs on the transmitter clock while bytes are taken and on the internal clock again before done.
- R5: Each bit lasts bit_div_i+1 transmitter clock cycles. Bits go out MSB first. When the next byte is already valid at the end of a byte, its MSB follows with no gap.
- R6: In amplitude keying, pa_enable_o equals the current bit (1 = on) and fsk_sw_o stays 0.
- R7: In frequency keying, pa_enable_o is 1 for the whole data phase. fsk_sw_o is 1 (switch closed, lower frequency) for a 0 bit and 0 (switch open) for a 1 bit.
- R8: After the last bit, pa_enable_o goes low first. The clock returns to internal, and only then does tx_enable_o fall.
- R9: done_o is high for exactly one internal cycle per burst, in the cycle where tx_enable_o is already 0. busy_o is 0 in the cycle after.
- R10: start_i, fsk_mode_i and bit_div_i are ignored while busy_o is 1. A start pulse during a burst changes neither the running burst nor what follows it.
- R11: If no byte is valid when a byte ends, the sequencer waits with byte_ready_o high. During the wait it holds pa_enable_o at 1 in frequency keying or 0 in amplitude keying, with fsk_sw_o at 0.
- R12: A byte is taken at a transmitter clock edge where byte_ready_o and byte_valid_i are both 1. A byte taken with byte_last_i = 1 is the last one, and byte_ready_o is not raised again in that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Free-running internal clock |
| clk_tx | input | 1 | Crystal-derived transmitter clock (runs only while enabled) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, sampled in standby |
| fsk_mode_i | input | 1 | 1 = frequency keying, 0 = amplitude keying |
| bit_div_i | input | DIV_W | Transmitter cycles per bit minus one |
| byte_data_i | input | BYTE_W | Next byte to send |
| byte_valid_i | input | 1 | byte_data_i holds a byte |
| byte_last_i | input | 1 | The offered byte is the final one |
| byte_ready_o | output | 1 | Sequencer takes the offered byte at this edge |
| tx_enable_o | output | 1 | Oscillator/PLL/clock-output enable |
| pa_enable_o | output | 1 | Power amplifier enable |
| fsk_sw_o | output | 1 | Crystal load-capacitor switch (1 = closed) |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
On every cycle, the assertions check the clock-gate exclusion and its ordering, the minimum warm-up before the clock hand-over, and that the switch is only active with the amplifier on in frequency keying. They also check that tx_enable_o falls only with the amplifier off and the internal clock back, that done is a single-cycle pulse with the enable low, and that the divider counter stays within range. Only the bench scenarios can show the bit values and their durations, the MSB-first order across back-to-back bytes, the level held while a byte is stalled, and that a start request during a burst leaves the mode and rate unchanged and starts no second burst. They alone can also show the data-rate corner with a divider of zero.

// File: rtl/rfseq_pkg.sv
`timescale 1ns/1ps
package rfseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_TO_TX,
    ST_LOAD,
    ST_BIT,
    ST_PA_OFF,
    ST_TO_INT,
    ST_DONE
  } seq_state_t;

  // States in which the sequencer must run on the transmitter clock.
  function automatic logic uses_tx_clk(input seq_state_t s);
    return (s == ST_TO_TX) || (s == ST_LOAD) || (s == ST_BIT) || (s == ST_PA_OFF);
  endfunction

  // States in which the oscillator/PLL enable is held high.
  function automatic logic osc_on(input seq_state_t s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction

  // Index of the final bit in a byte of the given width.
  function automatic int unsigned last_bit_index(input int unsigned width);
    return width - 1;
  endfunction

endpackage

// File: rtl/rfseq_clksw.sv
`timescale 1ns/1ps
module rfseq_clksw (
  input  logic clk_int,
  input  logic clk_tx,
  input  logic rst_n,
  input  logic sel_tx,
  output logic clk_out,
  output logic int_on,
  output logic tx_on
);

  logic int_s1;
  logic tx_s1;

  // Internal side: request stage on rising edge, gate enable on falling edge.
  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) int_s1 <= 1'b1;
    else        int_s1 <= ~sel_tx & ~tx_on;
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) int_on <= 1'b1;
    else        int_on <= int_s1;
  end

  // Transmitter side: mirror image, waits for the internal gate to close.
  always_ff @(posedge clk_tx or negedge rst_n) begin
    if (!rst_n) tx_s1 <= 1'b0;
    else        tx_s1 <= sel_tx & ~int_on;
  end

  always_ff @(negedge clk_tx or negedge rst_n) begin
    if (!rst_n) tx_on <= 1'b0;
    else        tx_on <= tx_s1;
  end

  assign clk_out = (clk_int & int_on) | (clk_tx & tx_on);

  // R4
  gate_excl_int_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(int_on && tx_on));
  // R4
  gate_excl_tx_chk: assert property (@(posedge clk_tx) disable iff (!rst_n)
    !(int_on && tx_on));
  // R4
  tx_after_int_chk: assert property (@(negedge clk_tx) disable iff (!rst_n)
    $rose(tx_on) |-> !int_on);

endmodule

// File: rtl/rfseq_warm.sv
`timescale 1ns/1ps
module rfseq_warm #(
  parameter int unsigned WARM_CYCLES = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + CW'(1);
  end

  // R3
  warm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/rfseq_bitser.sv
`timescale 1ns/1ps
module rfseq_bitser
  import rfseq_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_sel,
  output logic              cur_bit,
  output logic              bit_end,
  output logic              byte_end
);

  localparam int unsigned IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(last_bit_index(BYTE_W));

  logic [BYTE_W-1:0] shreg;
  logic [DIV_W-1:0]  div_cnt;
  logic [IW-1:0]     idx;

  assign cur_bit  = shreg[BYTE_W-1];
  assign bit_end  = run && (div_cnt == div_sel);
  assign byte_end = bit_end && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      div_cnt <= '0;
      idx     <= '0;
    end else if (load) begin
      shreg   <= load_data;
      div_cnt <= '0;
      idx     <= '0;
    end else if (run) begin
      if (bit_end) begin
        div_cnt <= '0;
        idx     <= idx + IW'(1);
        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  // R5
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= div_sel));

endmodule

// File: rtl/rf_burst_seq.sv
`timescale 1ns/1ps
module rf_burst_seq
  import rfseq_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 32000,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk_int,
  input  logic              clk_tx,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fsk_mode_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              tx_enable_o,
  output logic              pa_enable_o,
  output logic              fsk_sw_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_t       state, state_n;
  logic             seq_clk;
  logic             int_on, tx_on;
  logic             sel_tx_q;
  logic             mode_q;
  logic [DIV_W-1:0] div_q;
  logic             last_q;
  logic             warm_done;
  logic             cur_bit, bit_end, byte_end;
  logic             take_byte;

  rfseq_clksw u_clksw (
    .clk_int (clk_int),
    .clk_tx  (clk_tx),
    .rst_n   (rst_n),
    .sel_tx  (sel_tx_q),
    .clk_out (seq_clk),
    .int_on  (int_on),
    .tx_on   (tx_on)
  );

  rfseq_warm #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk   (seq_clk),
    .rst_n (rst_n),
    .run   (state == ST_WARM),
    .done  (warm_done)
  );

  rfseq_bitser #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_bitser (
    .clk       (seq_clk),
    .rst_n     (rst_n),
    .load      (take_byte),
    .load_data (byte_data_i),
    .run       (state == ST_BIT),
    .div_sel   (div_q),
    .cur_bit   (cur_bit),
    .bit_end   (bit_end),
    .byte_end  (byte_end)
  );

  assign byte_ready_o = (state == ST_LOAD) || ((state == ST_BIT) && byte_end && !last_q);
  assign take_byte    = byte_ready_o && byte_valid_i;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:   if (start_i) state_n = ST_WARM;
      ST_WARM:   if (warm_done) state_n = ST_TO_TX;
      ST_TO_TX:  if (tx_on) state_n = ST_LOAD;
      ST_LOAD:   if (byte_valid_i) state_n = ST_BIT;
      ST_BIT: begin
        if (byte_end) begin
          if (last_q)            state_n = ST_PA_OFF;
          else if (byte_valid_i) state_n = ST_BIT;
          else                   state_n = ST_LOAD;
        end
      end
      ST_PA_OFF: state_n = ST_TO_INT;
      ST_TO_INT: if (int_on) state_n = ST_DONE;
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge seq_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_tx_q <= 1'b0;
      mode_q   <= 1'b0;
      div_q    <= '0;
      last_q   <= 1'b0;
    end else begin
      state    <= state_n;
      sel_tx_q <= uses_tx_clk(state_n);
      if ((state == ST_IDLE) && start_i) begin
        mode_q <= fsk_mode_i;
        div_q  <= bit_div_i;
      end
      if (take_byte) last_q <= byte_last_i;
    end
  end

  always_comb begin
    pa_enable_o = 1'b0;
    fsk_sw_o    = 1'b0;
    if (state == ST_LOAD) begin
      pa_enable_o = mode_q;
    end else if (state == ST_BIT) begin
      pa_enable_o = mode_q | cur_bit;
      fsk_sw_o    = mode_q & ~cur_bit;
    end
  end

  assign tx_enable_o = osc_on(state);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);

  // Independent count of sequencer cycles since the enable rose.
  int unsigned en_age;
  always_ff @(posedge seq_clk or negedge rst_n) begin
    if (!rst_n)            en_age <= 0;
    else if (!tx_enable_o) en_age <= 0;
    else if (en_age < WARM_CYCLES + 2) en_age <= en_age + 1;
  end

  // R2
  start_enable_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    $rose(busy_o) |-> (tx_enable_o && !pa_enable_o));
  // R3
  warm_before_tx_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    $rose(sel_tx_q) |-> (en_age >= WARM_CYCLES));
  // R6
  ask_sw_idle_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    fsk_sw_o |-> mode_q);
  // R7
  sw_needs_pa_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    fsk_sw_o |-> pa_enable_o);
  // R8
  pa_needs_en_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    pa_enable_o |-> tx_enable_o);
  // R8
  shutdown_order_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    $fell(tx_enable_o) |-> (!pa_enable_o && int_on && !tx_on));
  // R9
  done_en_low_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    done_o |-> !tx_enable_o);
  // R9
  done_single_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R12
  ready_on_tx_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
    byte_ready_o |-> tx_on);

endmodule

// File: tb/rf_burst_seq_test.sv
`timescale 1ns/100ps
module rf_burst_seq_test;

  localparam int WARM = 100;
  localparam int DW   = 8;
  localparam int BW   = 8;

  logic          clk_int = 1'b0;
  logic          clk_tx  = 1'b0;
  logic          rst_n   = 1'b0;
  logic          start_i = 1'b0;
  logic          fsk_mode_i = 1'b0;
  logic [DW-1:0] bit_div_i = '0;
  logic [BW-1:0] byte_data_i = '0;
  logic          byte_valid_i = 1'b0;
  logic          byte_last_i = 1'b0;
  logic          byte_ready_o, tx_enable_o, pa_enable_o, fsk_sw_o, busy_o, done_o;

  rf_burst_seq #(.WARM_CYCLES(WARM), .DIV_W(DW), .BYTE_W(BW)) uut (
    .clk_int(clk_int), .clk_tx(clk_tx), .rst_n(rst_n),
    .start_i(start_i), .fsk_mode_i(fsk_mode_i), .bit_div_i(bit_div_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .tx_enable_o(tx_enable_o), .pa_enable_o(pa_enable_o),
    .fsk_sw_o(fsk_sw_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk_int = ~clk_int;

  // Transmitter clock: starts some time after enable, stops when it drops.
  initial forever begin
    wait (tx_enable_o === 1'b1);
    #400;
    while (tx_enable_o === 1'b1) #15.3 clk_tx = ~clk_tx;
    clk_tx = 1'b0;
  end

  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  // Reference model state
  logic [BW-1:0] q[$];
  bit   burst_fsk;
  int   burst_len;
  bit   in_burst = 0;
  bit   active = 0;
  int   pos;
  logic [BW-1:0] cur;
  int   consumed;
  bit   stall_req, stalling, stall_done;
  bit   extra_ready;
  int   int_cyc = 0;
  int   en_rise_cyc, en_fall_cyc, first_load_cyc, last_pa_fall_cyc;
  int   done_cnt;
  bit   pa_early, done_en_bad, busy_after_done_bad, pa_at_en_fall;
  bit   en_prev, pa_prev, done_prev;

  task automatic present();
    byte_data_i  <= q[0];
    byte_last_i  <= (q.size() == 1);
    byte_valid_i <= 1'b1;
  endtask

  // Byte source and model start on the transmitter clock.
  always @(posedge clk_tx) begin
    if (in_burst && byte_ready_o && byte_valid_i) begin
      cur = byte_data_i;
      pos = 0;
      active = 1;
      consumed++;
      if (consumed == 1) first_load_cyc = int_cyc;
      void'(q.pop_front());
      if (q.size() == 0) byte_valid_i <= 1'b0;
      else if (stall_req && !stall_done) begin
        byte_valid_i <= 1'b0;
        stalling = 1;
      end else present();
    end
  end

  // Cycle-by-cycle comparison of modulation outputs.
  always @(negedge clk_tx) begin
    if (in_burst) begin
      if (active) begin
        bit b;
        bit exp_pa, exp_sw;
        b = cur[BW-1-(pos/burst_len)];
        exp_pa = burst_fsk ? 1'b1 : b;
        exp_sw = burst_fsk ? ~b : 1'b0;
        chk(pa_enable_o == exp_pa, burst_fsk ? "R5 R7" : "R5 R6", "pa_enable per bit", int'(pa_enable_o), int'(exp_pa));
        chk(fsk_sw_o == exp_sw, burst_fsk ? "R5 R7" : "R5 R6", "fsk switch per bit", int'(fsk_sw_o), int'(exp_sw));
        pos++;
        if (pos == 8 * burst_len) active = 0;
      end else if (stalling) begin
        chk(pa_enable_o == burst_fsk, "R11", "pa held while stalled", int'(pa_enable_o), int'(burst_fsk));
        chk(fsk_sw_o == 1'b0, "R11", "switch open while stalled", int'(fsk_sw_o), 0);
        chk(byte_ready_o == 1'b1, "R11", "ready while stalled", int'(byte_ready_o), 1);
      end
      if (byte_ready_o && q.size() == 0 && consumed > 0) extra_ready = 1;
    end
  end

  // Internal-clock monitor.
  always @(negedge clk_int) begin
    int_cyc++;
    if (in_burst) begin
      if (tx_enable_o && !en_prev) en_rise_cyc = int_cyc;
      if (!tx_enable_o && en_prev) begin
        en_fall_cyc = int_cyc;
        pa_at_en_fall = pa_enable_o;
      end
      if (pa_enable_o && tx_enable_o && (int_cyc - en_rise_cyc < WARM)) pa_early = 1;
      if (!pa_enable_o && pa_prev) last_pa_fall_cyc = int_cyc;
      if (done_o) begin
        done_cnt++;
        if (tx_enable_o) done_en_bad = 1;
      end
      if (done_prev && busy_o) busy_after_done_bad = 1;
    end
    en_prev   = tx_enable_o;
    pa_prev   = pa_enable_o;
    done_prev = done_o;
  end

  task automatic run_burst(input bit fsk, input int div, input logic [BW-1:0] data[$],
                           input bit stall, input bit poke);
    int nbytes;
    nbytes = data.size();
    q = data;
    burst_fsk = fsk; burst_len = div + 1;
    consumed = 0; active = 0; stall_req = stall; stalling = 0; stall_done = 0;
    extra_ready = 0; done_cnt = 0; pa_early = 0; done_en_bad = 0;
    busy_after_done_bad = 0; pa_at_en_fall = 0;
    en_rise_cyc = 0; en_fall_cyc = 0; first_load_cyc = 0; last_pa_fall_cyc = 0;
    in_burst = 1;
    @(negedge clk_int);
    present();
    bit_div_i <= DW'(div); fsk_mode_i <= fsk; start_i <= 1'b1;
    @(negedge clk_int);
    start_i <= 1'b0;
    // R2: one internal edge after the request
    chk(tx_enable_o == 1'b1, "R2", "enable after start", int'(tx_enable_o), 1);
    chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    chk(pa_enable_o == 1'b0, "R2", "pa low after start", int'(pa_enable_o), 0);
    if (poke) begin
      repeat (20) @(negedge clk_int);
      start_i <= 1'b1; fsk_mode_i <= ~fsk; bit_div_i <= DW'(div + 2);
      @(negedge clk_int);
      start_i <= 1'b0;
      chk(tx_enable_o == 1'b1 && busy_o == 1'b1, "R10", "burst unaffected by start while busy",
          int'(busy_o), 1);
    end
    if (stall) begin
      wait (stalling);
      repeat (24) @(posedge clk_tx);
      present();
      stall_done = 1;
      stalling = 0;
    end
    wait (done_cnt != 0);
    repeat (30) @(negedge clk_int);
    chk(consumed == nbytes, "R12", "bytes taken", consumed, nbytes);
    chk(!extra_ready, "R12", "ready after last byte", int'(extra_ready), 0);
    chk(first_load_cyc - en_rise_cyc >= WARM, "R3", "cycles before first byte",
        first_load_cyc - en_rise_cyc, WARM);
    chk(!pa_early, "R3", "pa during warm-up", int'(pa_early), 0);
    chk(last_pa_fall_cyc < en_fall_cyc, "R8", "pa falls before enable", last_pa_fall_cyc, en_fall_cyc);
    chk(!pa_at_en_fall, "R8", "pa at enable fall", int'(pa_at_en_fall), 0);
    chk(done_cnt == 1, "R9", "done pulse samples", done_cnt, 1);
    chk(!done_en_bad, "R9", "enable during done", int'(done_en_bad), 0);
    chk(!busy_after_done_bad, "R4", "back on internal clock after done", int'(busy_after_done_bad), 0);
    chk(busy_o == 1'b0 && tx_enable_o == 1'b0, "R10", "no second burst", int'(busy_o), 0);
    chk(!active && !stalling, "R5", "all bits observed", int'(active), 0);
    in_burst = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk_int);
    chk(tx_enable_o == 0 && pa_enable_o == 0, "R1", "enable/pa in reset", int'(tx_enable_o), 0);
    chk(fsk_sw_o == 0 && busy_o == 0, "R1", "switch/busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_int);
    chk(tx_enable_o == 0 && pa_enable_o == 0, "R1", "enable/pa after reset", int'(pa_enable_o), 0);
    chk(done_o == 0 && byte_ready_o == 0, "R1", "done/ready after reset", int'(done_o), 0);
    chk(fsk_sw_o == 0 && busy_o == 0, "R1", "switch/busy after reset", int'(fsk_sw_o), 0);

    run_burst(1'b0, 3, '{8'hA5, 8'h3C}, 1'b0, 1'b1);
    run_burst(1'b1, 2, '{8'h96, 8'h0F, 8'hC3}, 1'b1, 1'b0);
    run_burst(1'b0, 0, '{8'h81}, 1'b0, 1'b0);
    run_burst(1'b1, 5, '{8'h00, 8'hFF}, 1'b1, 1'b1);

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_int);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish got=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule